// File: doc/BRIEF.md
# Outstanding Request Tracking Table

This block keeps one record for every split-transaction bus request that is still waiting for its response. Every cache controller holds an identical copy. When a request commits on the bus, the record chosen by the request's bus tag is filled in. The record holds:

- the block address;
- the request kind;
- whether this controller wants to capture the returning data;
- whether this controller originated the request;
- the local snoop state, which starts as pending and is updated once the local lookup resolves.

When a response carrying that tag appears, the record is released and the tag can be handed out again.

Two address lookups run every cycle in parallel against all live records, one from the bus side and one from the processor side. Both compare at cache-block granularity. The processor-side lookup also returns a verdict for the issue logic:

- **issue**: the request may go out.
- **join**: an outstanding read to the same block exists, and this controller should capture that read's data instead of issuing.
- **retry**: an incompatible request to the same block is in flight, so the request must wait.

On a response, the block reports whether this controller wants the data. It also reports whether it must assert the shared line, which happens when it captures data it did not request.

Top module: `req_track_table`

## Requirements
- R1: After synchronous reset all NUM_TAGS records (default 8, one per 3-bit tag) are free. Every lookup misses, and on a miss the reported tag and state read 0.
- R2: When alloc_valid is high at a clock edge, the record at alloc_tag becomes live. From the next cycle a lookup of that block hits and reports that tag, with snoop state pending (code 0).
- R3: Addresses are compared at block granularity of BLK_BYTES (default 128). Addresses that differ only in the low log2(BLK_BYTES) bits match. A difference in any higher bit misses.
- R4: A resp_valid at a clock edge frees the record at resp_tag, and later lookups of its block miss. If alloc_valid names the same tag in the same cycle, the allocation wins and the record holds the new request.
- R5: The bus-side lookup and the processor-side lookup are evaluated independently and in parallel within the same cycle. Both are combinational.
- R6: When two or more live records hold the same block, the lookup raises its multi flag and reports the lowest matching tag.
- R7: The processor verdict uses kind codes 0 = read, 1 = exclusive read, 2 = upgrade, 3 = writeback. Exactly one verdict output is high:
  - cpu_issue_ok when there is no hit;
  - cpu_join when there is a hit, the new kind is read and the reported record's kind is read;
  - cpu_retry otherwise.
- R8: While resp_valid is high, resp_grab equals (record live and want-data set) for the record at resp_tag, and resp_shared equals (resp_grab and originator clear). A free record gives 0 on both.
- R9: A snoop update (snp_valid) writes snp_state into a live record at snp_tag. The bus-side lookup reports the stored state of the record it hits. State codes are 0 = pending, 1 = clean, 2 = shared, 3 = dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A request committed on the bus this cycle |
| alloc_tag | input | TAG_W | Bus tag of the committed request |
| alloc_addr | input | ADDR_W | Address of the committed request |
| alloc_kind | input | 2 | Request kind code |
| alloc_want_data | input | 1 | This controller will capture the response data |
| alloc_originator | input | 1 | This controller issued the request |
| snp_valid | input | 1 | Local snoop result is ready |
| snp_tag | input | TAG_W | Record that the snoop result belongs to |
| snp_state | input | 2 | Snoop state code |
| resp_valid | input | 1 | A response is on the bus this cycle |
| resp_tag | input | TAG_W | Tag carried by the response |
| resp_shared | output | 1 | Assert the shared line for this response |
| resp_grab | output | 1 | Capture the data of this response |
| bus_lk_addr | input | ADDR_W | Bus-side lookup address |
| bus_lk_hit | output | 1 | Bus lookup matches a live record |
| bus_lk_multi | output | 1 | Bus lookup matches more than one record |
| bus_lk_tag | output | TAG_W | Lowest matching tag on the bus side |
| bus_lk_state | output | 2 | Snoop state of the matching record |
| cpu_lk_addr | input | ADDR_W | Processor-side lookup address |
| cpu_lk_kind | input | 2 | Kind of the request the processor side wants to issue |
| cpu_lk_hit | output | 1 | Processor lookup matches a live record |
| cpu_lk_multi | output | 1 | Processor lookup matches more than one record |
| cpu_lk_tag | output | TAG_W | Lowest matching tag on the processor side |
| cpu_issue_ok | output | 1 | New request may be issued |
| cpu_join | output | 1 | Capture the outstanding read's data instead of issuing |
| cpu_retry | output | 1 | Incompatible request in flight; wait and retry |

## Verification
The bench builds the table with eight tags, 128-byte blocks and a 20-bit address. The narrow address keeps the test addresses short while still leaving thirteen bits of block number, so bit 7 can be flipped to show the granularity boundary. Eight tags put the highest tag, 7, within reach, along with the free-before-reuse case where a tag is released and reissued in the same cycle. Two records are placed on one block to exercise multi-hit resolution, and the three issue verdicts are reached against read, exclusive-read and writeback entries.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    typedef enum logic [1:0] {
        RK_READ  = 2'd0,
        RK_READX = 2'd1,
        RK_UPGR  = 2'd2,
        RK_WBACK = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        SS_PENDING = 2'd0,
        SS_CLEAN   = 2'd1,
        SS_SHARED  = 2'd2,
        SS_DIRTY   = 2'd3
    } snp_state_e;

    typedef struct packed {
        logic       want_data;
        logic       originator;
        req_kind_e  kind;
        snp_state_e snoop;
    } entry_attr_t;

    typedef enum logic [1:0] {
        IV_ISSUE = 2'd0,
        IV_JOIN  = 2'd1,
        IV_RETRY = 2'd2
    } issue_verdict_e;

    // A read may share an in-flight read; any other pairing must wait.
    function automatic issue_verdict_e judge_issue(
        input logic      hit,
        input req_kind_e prior,
        input req_kind_e fresh
    );
        if (!hit)
            return IV_ISSUE;
        else if (prior == RK_READ && fresh == RK_READ)
            return IV_JOIN;
        else
            return IV_RETRY;
    endfunction

endpackage

// File: rtl/rtt_entry_store.sv
module rtt_entry_store
    import rtt_pkg::*;
#(
    parameter int NUM   = 8,
    parameter int TAG_W = 3,
    parameter int BLK_W = 33
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alloc_valid,
    input  logic [TAG_W-1:0]              alloc_tag,
    input  logic [BLK_W-1:0]              alloc_blk,
    input  entry_attr_t                   alloc_attr,
    input  logic                          snp_valid,
    input  logic [TAG_W-1:0]              snp_tag,
    input  snp_state_e                    snp_state,
    input  logic                          free_valid,
    input  logic [TAG_W-1:0]              free_tag,
    output logic [NUM-1:0]                valid_o,
    output logic [NUM-1:0][BLK_W-1:0]     blk_o,
    output entry_attr_t [NUM-1:0]         attr_o
);

    for (genvar i = 0; i < NUM; i++) begin : g_rec
        logic        v_q;
        logic [BLK_W-1:0] blk_q;
        entry_attr_t attr_q;

        wire hit_alloc = alloc_valid && (alloc_tag == TAG_W'(i));
        wire hit_free  = free_valid  && (free_tag  == TAG_W'(i));
        wire hit_snp   = snp_valid   && (snp_tag   == TAG_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q    <= 1'b0;
                blk_q  <= '0;
                attr_q <= '0;
            end else if (hit_alloc) begin
                v_q          <= 1'b1;
                blk_q        <= alloc_blk;
                attr_q       <= alloc_attr;
                attr_q.snoop <= SS_PENDING;
            end else begin
                if (hit_free)
                    v_q <= 1'b0;
                if (hit_snp && v_q)
                    attr_q.snoop <= snp_state;
            end
        end

        assign valid_o[i] = v_q;
        assign blk_o[i]   = blk_q;
        assign attr_o[i]  = attr_q;
    end

endmodule

// File: rtl/rtt_match.sv
module rtt_match #(
    parameter int NUM   = 8,
    parameter int TAG_W = 3,
    parameter int BLK_W = 33
) (
    input  logic [NUM-1:0]            valid_i,
    input  logic [NUM-1:0][BLK_W-1:0] blk_i,
    input  logic [BLK_W-1:0]          key_i,
    output logic                      hit_o,
    output logic                      multi_o,
    output logic [TAG_W-1:0]          tag_o
);

    logic [NUM-1:0] hit_vec;

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        assign hit_vec[i] = valid_i[i] && (blk_i[i] == key_i);
    end

    always_comb begin
        tag_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_vec[i])
                tag_o = TAG_W'(i);
        end
    end

    assign hit_o   = |hit_vec;
    assign multi_o = ($countones(hit_vec) > 1);

endmodule

// File: rtl/req_track_table.sv
module req_track_table
    import rtt_pkg::*;
#(
    parameter int NUM_TAGS  = 8,
    parameter int ADDR_W    = 40,
    parameter int BLK_BYTES = 128,
    localparam int TAG_W    = $clog2(NUM_TAGS),
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int BLK_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [1:0]        alloc_kind,
    input  logic              alloc_want_data,
    input  logic              alloc_originator,
    input  logic              snp_valid,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [1:0]        snp_state,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    output logic              resp_shared,
    output logic              resp_grab,
    input  logic [ADDR_W-1:0] bus_lk_addr,
    output logic              bus_lk_hit,
    output logic              bus_lk_multi,
    output logic [TAG_W-1:0]  bus_lk_tag,
    output logic [1:0]        bus_lk_state,
    input  logic [ADDR_W-1:0] cpu_lk_addr,
    input  logic [1:0]        cpu_lk_kind,
    output logic              cpu_lk_hit,
    output logic              cpu_lk_multi,
    output logic [TAG_W-1:0]  cpu_lk_tag,
    output logic              cpu_issue_ok,
    output logic              cpu_join,
    output logic              cpu_retry
);

    logic [NUM_TAGS-1:0]            entry_valid;
    logic [NUM_TAGS-1:0][BLK_W-1:0] entry_blk;
    entry_attr_t [NUM_TAGS-1:0]     entry_attr;
    entry_attr_t                    new_attr;
    issue_verdict_e                 verdict;

    // Offset bits within a block never take part in matching.
    logic unused_offset_bits;
    assign unused_offset_bits = ^{alloc_addr[OFF_W-1:0],
                                  bus_lk_addr[OFF_W-1:0],
                                  cpu_lk_addr[OFF_W-1:0]};

    always_comb begin
        new_attr            = '0;
        new_attr.want_data  = alloc_want_data;
        new_attr.originator = alloc_originator;
        new_attr.kind       = req_kind_e'(alloc_kind);
        new_attr.snoop      = SS_PENDING;
    end

    rtt_entry_store #(
        .NUM   (NUM_TAGS),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .alloc_tag   (alloc_tag),
        .alloc_blk   (alloc_addr[ADDR_W-1:OFF_W]),
        .alloc_attr  (new_attr),
        .snp_valid   (snp_valid),
        .snp_tag     (snp_tag),
        .snp_state   (snp_state_e'(snp_state)),
        .free_valid  (resp_valid),
        .free_tag    (resp_tag),
        .valid_o     (entry_valid),
        .blk_o       (entry_blk),
        .attr_o      (entry_attr)
    );

    rtt_match #(
        .NUM   (NUM_TAGS),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
    ) u_bus_match (
        .valid_i (entry_valid),
        .blk_i   (entry_blk),
        .key_i   (bus_lk_addr[ADDR_W-1:OFF_W]),
        .hit_o   (bus_lk_hit),
        .multi_o (bus_lk_multi),
        .tag_o   (bus_lk_tag)
    );

    rtt_match #(
        .NUM   (NUM_TAGS),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
    ) u_cpu_match (
        .valid_i (entry_valid),
        .blk_i   (entry_blk),
        .key_i   (cpu_lk_addr[ADDR_W-1:OFF_W]),
        .hit_o   (cpu_lk_hit),
        .multi_o (cpu_lk_multi),
        .tag_o   (cpu_lk_tag)
    );

    assign bus_lk_state = bus_lk_hit ? entry_attr[bus_lk_tag].snoop : 2'd0;

    assign verdict      = judge_issue(cpu_lk_hit, entry_attr[cpu_lk_tag].kind,
                                      req_kind_e'(cpu_lk_kind));
    assign cpu_issue_ok = (verdict == IV_ISSUE);
    assign cpu_join     = (verdict == IV_JOIN);
    assign cpu_retry    = (verdict == IV_RETRY);

    assign resp_grab   = resp_valid && entry_valid[resp_tag]
                         && entry_attr[resp_tag].want_data;
    assign resp_shared = resp_grab && !entry_attr[resp_tag].originator;

endmodule

// File: rtl/req_track_table_chk.sv
module req_track_table_chk #(
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                alloc_valid,
    input logic [TAG_W-1:0]    alloc_tag,
    input logic                resp_valid,
    input logic [TAG_W-1:0]    resp_tag,
    input logic [NUM_TAGS-1:0] valid_vec,
    input logic                bus_lk_hit,
    input logic                bus_lk_multi,
    input logic [TAG_W-1:0]    bus_lk_tag,
    input logic                cpu_lk_hit,
    input logic                cpu_issue_ok,
    input logic                cpu_join,
    input logic                cpu_retry,
    input logic                resp_shared,
    input logic                resp_grab
);

    assert_alloc_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> valid_vec[$past(alloc_tag)]);

    assert_resp_frees_R4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !(alloc_valid && alloc_tag == resp_tag))
        |=> !valid_vec[$past(resp_tag)]);

    assert_alloc_tag_free_R4: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !(resp_valid && resp_tag == alloc_tag))
        |-> !valid_vec[alloc_tag]);

    assert_hit_on_live_R6: assert property (@(posedge clk) disable iff (rst)
        bus_lk_hit |-> valid_vec[bus_lk_tag]);

    assert_multi_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        bus_lk_multi |-> bus_lk_hit);

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (rst)
        $countones({cpu_issue_ok, cpu_join, cpu_retry}) == 1);

    assert_issue_only_on_miss_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_issue_ok |-> !cpu_lk_hit);

    assert_shared_needs_grab_R8: assert property (@(posedge clk) disable iff (rst)
        resp_shared |-> (resp_grab && resp_valid));

endmodule

bind req_track_table req_track_table_chk #(
    .NUM_TAGS (NUM_TAGS),
    .TAG_W    (TAG_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .alloc_valid  (alloc_valid),
    .alloc_tag    (alloc_tag),
    .resp_valid   (resp_valid),
    .resp_tag     (resp_tag),
    .valid_vec    (entry_valid),
    .bus_lk_hit   (bus_lk_hit),
    .bus_lk_multi (bus_lk_multi),
    .bus_lk_tag   (bus_lk_tag),
    .cpu_lk_hit   (cpu_lk_hit),
    .cpu_issue_ok (cpu_issue_ok),
    .cpu_join     (cpu_join),
    .cpu_retry    (cpu_retry),
    .resp_shared  (resp_shared),
    .resp_grab    (resp_grab)
);

// File: tb/test_req_track_table.sv
module test_req_track_table;

    localparam int AW = 20;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_valid = 1'b0;
    logic [TW-1:0] alloc_tag = '0;
    logic [AW-1:0] alloc_addr = '0;
    logic [1:0]    alloc_kind = '0;
    logic          alloc_want_data = 1'b0;
    logic          alloc_originator = 1'b0;
    logic          snp_valid = 1'b0;
    logic [TW-1:0] snp_tag = '0;
    logic [1:0]    snp_state = '0;
    logic          resp_valid = 1'b0;
    logic [TW-1:0] resp_tag = '0;
    logic          resp_shared, resp_grab;
    logic [AW-1:0] bus_lk_addr = '0;
    logic          bus_lk_hit, bus_lk_multi;
    logic [TW-1:0] bus_lk_tag;
    logic [1:0]    bus_lk_state;
    logic [AW-1:0] cpu_lk_addr = '0;
    logic [1:0]    cpu_lk_kind = '0;
    logic          cpu_lk_hit, cpu_lk_multi;
    logic [TW-1:0] cpu_lk_tag;
    logic          cpu_issue_ok, cpu_join, cpu_retry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    req_track_table #(.NUM_TAGS(8), .ADDR_W(AW), .BLK_BYTES(128)) i_req_track_table (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
        .alloc_kind(alloc_kind), .alloc_want_data(alloc_want_data),
        .alloc_originator(alloc_originator),
        .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_state(snp_state),
        .resp_valid(resp_valid), .resp_tag(resp_tag),
        .resp_shared(resp_shared), .resp_grab(resp_grab),
        .bus_lk_addr(bus_lk_addr), .bus_lk_hit(bus_lk_hit), .bus_lk_multi(bus_lk_multi),
        .bus_lk_tag(bus_lk_tag), .bus_lk_state(bus_lk_state),
        .cpu_lk_addr(cpu_lk_addr), .cpu_lk_kind(cpu_lk_kind), .cpu_lk_hit(cpu_lk_hit),
        .cpu_lk_multi(cpu_lk_multi), .cpu_lk_tag(cpu_lk_tag),
        .cpu_issue_ok(cpu_issue_ok), .cpu_join(cpu_join), .cpu_retry(cpu_retry)
    );

    // Scoreboard item: sel 0 = bus lookup, 1 = cpu lookup, 2 = response flags.
    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];

    function automatic logic [7:0] bexp(logic h, logic m, logic [2:0] t, logic [1:0] s);
        return {1'b0, h, m, t, s};
    endfunction

    // verdict: 0 issue, 1 join, 2 retry
    function automatic logic [7:0] cexp(logic h, logic m, logic [2:0] t, int v);
        return {h, m, t, (v == 0), (v == 1), (v == 2)};
    endfunction

    function automatic logic [7:0] rexp(logic sh, logic gr);
        return {6'b0, sh, gr};
    endfunction

    // Monitor: compares every queued item in the middle of the cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sb_q.pop_front();
            case (it.sel)
                0:       got = {1'b0, bus_lk_hit, bus_lk_multi, bus_lk_tag, bus_lk_state};
                1:       got = {cpu_lk_hit, cpu_lk_multi, cpu_lk_tag,
                                cpu_issue_ok, cpu_join, cpu_retry};
                default: got = {6'b0, resp_shared, resp_grab};
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %b expected %b", it.req, got, it.exp);
            end
        end
    end

    task automatic push(string req, int sel, logic [7:0] exp);
        item_t it;
        it.req = req;
        it.sel = sel;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic do_alloc(logic [2:0] t, logic [AW-1:0] a, logic [1:0] k, logic g, logic o);
        @(posedge clk); #2;
        alloc_valid = 1'b1; alloc_tag = t; alloc_addr = a;
        alloc_kind = k; alloc_want_data = g; alloc_originator = o;
        @(posedge clk); #2;
        alloc_valid = 1'b0;
    endtask

    task automatic do_snoop(logic [2:0] t, logic [1:0] s);
        @(posedge clk); #2;
        snp_valid = 1'b1; snp_tag = t; snp_state = s;
        @(posedge clk); #2;
        snp_valid = 1'b0;
    endtask

    task automatic do_resp(string req, logic [2:0] t, logic [7:0] exp);
        @(posedge clk); #2;
        resp_valid = 1'b1; resp_tag = t;
        push(req, 2, exp);
        @(posedge clk); #2;
        resp_valid = 1'b0;
    endtask

    task automatic alloc_and_resp(string req, logic [2:0] t, logic [AW-1:0] a,
                                  logic [1:0] k, logic g, logic o, logic [7:0] exp);
        @(posedge clk); #2;
        alloc_valid = 1'b1; alloc_tag = t; alloc_addr = a;
        alloc_kind = k; alloc_want_data = g; alloc_originator = o;
        resp_valid = 1'b1; resp_tag = t;
        push(req, 2, exp);
        @(posedge clk); #2;
        alloc_valid = 1'b0; resp_valid = 1'b0;
    endtask

    task automatic look_bus(string req, logic [AW-1:0] a, logic [7:0] exp);
        @(posedge clk); #2;
        bus_lk_addr = a;
        push(req, 0, exp);
    endtask

    task automatic look_cpu(string req, logic [AW-1:0] a, logic [1:0] k, logic [7:0] exp);
        @(posedge clk); #2;
        cpu_lk_addr = a; cpu_lk_kind = k;
        push(req, 1, exp);
    endtask

    task automatic look_both(string req, logic [AW-1:0] ab, logic [7:0] eb,
                             logic [AW-1:0] ac, logic [1:0] k, logic [7:0] ec);
        @(posedge clk); #2;
        bus_lk_addr = ab; cpu_lk_addr = ac; cpu_lk_kind = k;
        push({req, " bus"}, 0, eb);
        push({req, " cpu"}, 1, ec);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1: empty after reset
        look_bus("R1 bus miss after reset", 20'h00000, bexp(0, 0, 0, 0));
        look_bus("R1 bus miss high addr", 20'hFFF80, bexp(0, 0, 0, 0));
        look_cpu("R1 cpu issue after reset", 20'h00000, 2'd0, cexp(0, 0, 0, 0));

        // R2/R3: record at tag 3, read, grab, originator
        do_alloc(3'd3, 20'h01280, 2'd0, 1'b1, 1'b1);
        look_bus("R2 R3 hit within block", 20'h012FF, bexp(1, 0, 3, 0));
        look_bus("R3 next block misses", 20'h01300, bexp(0, 0, 0, 0));
        look_bus("R3 previous block misses", 20'h0127F, bexp(0, 0, 0, 0));
        look_cpu("R7 read joins read", 20'h012C5, 2'd0, cexp(1, 0, 3, 1));
        look_cpu("R7 exclusive read retries", 20'h01280, 2'd1, cexp(1, 0, 3, 2));
        look_cpu("R7 upgrade retries", 20'h01280, 2'd2, cexp(1, 0, 3, 2));

        // R9: snoop state update
        do_snoop(3'd3, 2'd3);
        look_bus("R9 dirty state reported", 20'h01280, bexp(1, 0, 3, 3));

        // tag 7, exclusive read captured but not originated
        do_alloc(3'd7, 20'hABC00, 2'd1, 1'b1, 1'b0);
        look_cpu("R7 read behind exclusive retries", 20'hABC10, 2'd0, cexp(1, 0, 7, 2));
        look_both("R5 parallel lookups", 20'h01280, bexp(1, 0, 3, 3),
                  20'hABC7F, 2'd0, cexp(1, 0, 7, 2));

        // R6: second record on the same block
        do_alloc(3'd6, 20'h01290, 2'd0, 1'b0, 1'b1);
        look_bus("R6 multi hit lowest tag", 20'h01280, bexp(1, 1, 3, 3));
        look_cpu("R6 cpu multi hit", 20'h01280, 2'd0, cexp(1, 1, 3, 1));

        // R8/R4: responses
        do_resp("R8 originator grab no shared", 3'd3, rexp(0, 1));
        look_bus("R4 freed tag leaves other record", 20'h01280, bexp(1, 0, 6, 0));
        do_resp("R8 non-originator grab asserts shared", 3'd7, rexp(1, 1));
        look_cpu("R4 R7 freed block issues", 20'hABC00, 2'd1, cexp(0, 0, 0, 0));
        do_resp("R8 free record gives nothing", 3'd0, rexp(0, 0));

        // R4: same-cycle free and reuse of tag 6
        alloc_and_resp("R8 R4 response before reuse", 3'd6, 20'h55500, 2'd3,
                       1'b0, 1'b1, rexp(0, 0));
        look_bus("R4 reused tag holds new block", 20'h55500, bexp(1, 0, 6, 0));
        look_bus("R4 old block gone", 20'h01280, bexp(0, 0, 0, 0));
        look_cpu("R7 read behind writeback retries", 20'h55510, 2'd0, cexp(1, 0, 6, 2));

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule